// File: doc/BRIEF.md
# Three-Product Complex Multiplier

This block forms the product of two complex operands, each carried as a signed 8-bit real part and a signed 8-bit imaginary part. The first operand is written A + jB and the second C + jD. The block returns the real part AC - BD and the imaginary part AD + BC at full 17-bit precision. Beside these it gives an 8-bit copy of each part, holding only the upper bits. A single input selects whether that narrow copy is truncated or rounded.

Only three real products are formed, not four: AC, BD and (A+B)(C+D). Two pre-adders widen the operand sums to 9 bits. The outputs are then rebuilt with subtractions: real = AC - BD, and imaginary = (A+B)(C+D) - AC - BD.

The `SHARED` parameter picks one of two structures:

- **Pipelined (`SHARED = 0`).** Three multipliers feed a five-register pipeline. The block takes a new operand pair on every clock, and a valid bit travels with the data.
- **Time-shared (`SHARED = 1`).** A single multiplier is stepped by a small state machine. It uses five states:
  - IDLE: waiting for a sample.
  - MUL_AC: forms AC.
  - MUL_BD: forms BD.
  - MUL_SUM: forms the product of the two sums.
  - COMBINE: builds and registers the result.

  The transitions are:
  - IDLE to MUL_AC when in_valid is seen while idle.
  - MUL_AC to MUL_BD, MUL_BD to MUL_SUM and MUL_SUM to COMBINE, each unconditionally.
  - COMBINE back to IDLE, with the result presented.

  in_ready is high only in IDLE.

Top module: `cmul3`

## Requirements
- R1: In pipelined mode in_ready is held at 1 and an operand pair is accepted on every clock edge where in_valid is 1, including back-to-back edges.
- R2: out_re is the signed 17-bit value a_re*b_re - a_im*b_im of the accepted operands (all operands two's complement).
- R3: out_im is the signed 17-bit value a_re*b_im + a_im*b_re of the accepted operands.
- R4: out_valid is 1 for exactly one cycle per accepted sample, five clock edges after the edge that accepted it, and the data shown with it belongs to that sample.
- R5: When rnd_sel is 0, out_re_n and out_im_n equal bits 16 down to 9 of out_re and out_im, which is floor(x / 512).
- R6: When rnd_sel is 1, out_re_n and out_im_n equal floor((x + 256) / 512), so halfway cases round towards positive infinity.
- R7: While reset is asserted and after it is released with no input, out_valid is 0, out_re and out_im are 0, and in_ready is 1.
- R8: In time-shared mode in_ready falls on the edge after a sample is accepted and stays low for four cycles. It is high again in the same cycle as the single-cycle out_valid pulse.
- R9: In time-shared mode in_valid and operand values presented while in_ready is 0 are ignored: they neither alter the result in progress nor produce any extra result.
- R10: Operands at -128 give exact results at the range limits, including an imaginary part of +32768 for (-128 - j128)(-128 - j128).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can accept a pair this cycle |
| a_re | input | 8 | Real part A of the first operand |
| a_im | input | 8 | Imaginary part B of the first operand |
| b_re | input | 8 | Real part C of the second operand |
| b_im | input | 8 | Imaginary part D of the second operand |
| rnd_sel | input | 1 | Narrow output mode: 0 truncates, 1 rounds |
| out_valid | output | 1 | Result present, one cycle per sample |
| out_re | output | 17 | Full-precision real part |
| out_im | output | 17 | Full-precision imaginary part |
| out_re_n | output | 8 | Upper 8 bits of the real part |
| out_im_n | output | 8 | Upper 8 bits of the imaginary part |

## Verification
The assertions compare out_re and out_im against the operands seen five edges earlier. They therefore take for granted that every operand is driven to a known value in each cycle after reset, accepted or not, and the stimulus never leaves an operand undriven. The narrow-output checks read rnd_sel in the cycle the result is shown, so the stimulus changes rnd_sel only after the pipeline has drained. In time-shared mode the checker assumes in_valid means nothing while in_ready is low. The stimulus deliberately holds in_valid high with junk operands during a busy window, to show that nothing is accepted there.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;
    // Multiplier section depth; one more register forms the output stage.
    localparam int MUL_DEPTH = 4;
    localparam int LATENCY   = MUL_DEPTH + 1;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_MUL_AC,
        TS_MUL_BD,
        TS_MUL_SUM,
        TS_COMBINE
    } ts_state_e;
endpackage

// File: rtl/cmul3_pipe.sv
module cmul3_pipe
    import cmul3_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic signed [W-1:0]   a,
    input  logic signed [W-1:0]   b,
    input  logic signed [W-1:0]   c,
    input  logic signed [W-1:0]   d,
    output logic                  out_valid,
    output logic signed [2*W:0]   out_re,
    output logic signed [2*W:0]   out_im
);
    localparam int SW  = W + 1;
    localparam int MW  = 2 * W;
    localparam int PW  = 2 * W + 2;
    localparam int RW  = 2 * W + 1;
    localparam int DLY = MUL_DEPTH - 2;

    // Stage 1: operands and pre-adder sums
    logic signed [W-1:0]  s1_a, s1_b, s1_c, s1_d;
    logic signed [SW-1:0] s1_sab, s1_scd;
    // Stages 2..MUL_DEPTH: products and their balancing registers
    logic signed [PW-1:0] m0_q [0:DLY];
    logic signed [MW-1:0] m1_q [0:DLY];
    logic signed [MW-1:0] m2_q [0:DLY];
    logic [LATENCY-1:0]   vld_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_a   <= '0;
            s1_b   <= '0;
            s1_c   <= '0;
            s1_d   <= '0;
            s1_sab <= '0;
            s1_scd <= '0;
            for (int k = 0; k <= DLY; k++) begin
                m0_q[k] <= '0;
                m1_q[k] <= '0;
                m2_q[k] <= '0;
            end
            out_re <= '0;
            out_im <= '0;
            vld_sr <= '0;
        end else begin
            s1_a   <= a;
            s1_b   <= b;
            s1_c   <= c;
            s1_d   <= d;
            s1_sab <= SW'(a) + SW'(b);
            s1_scd <= SW'(c) + SW'(d);
            m0_q[0] <= PW'(s1_sab) * PW'(s1_scd);
            m1_q[0] <= MW'(s1_a) * MW'(s1_c);
            m2_q[0] <= MW'(s1_b) * MW'(s1_d);
            for (int k = 1; k <= DLY; k++) begin
                m0_q[k] <= m0_q[k-1];
                m1_q[k] <= m1_q[k-1];
                m2_q[k] <= m2_q[k-1];
            end
            out_re <= RW'(m1_q[DLY]) - RW'(m2_q[DLY]);
            out_im <= RW'(m0_q[DLY] - PW'(m1_q[DLY]) - PW'(m2_q[DLY]));
            vld_sr <= {vld_sr[LATENCY-2:0], in_valid};
        end
    end

    assign out_valid = vld_sr[LATENCY-1];
endmodule

// File: rtl/cmul3_seq.sv
module cmul3_seq
    import cmul3_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic signed [W-1:0]   a,
    input  logic signed [W-1:0]   b,
    input  logic signed [W-1:0]   c,
    input  logic signed [W-1:0]   d,
    output logic                  out_valid,
    output logic signed [2*W:0]   out_re,
    output logic signed [2*W:0]   out_im
);
    localparam int SW = W + 1;
    localparam int MW = 2 * W;
    localparam int PW = 2 * W + 2;
    localparam int RW = 2 * W + 1;

    ts_state_e state, state_nx;

    logic signed [SW-1:0] ra, rb, rc, rd, rsab, rscd;
    logic signed [SW-1:0] op_x, op_y;
    logic signed [PW-1:0] prod;
    logic signed [MW-1:0] p_ac, p_bd;
    logic signed [PW-1:0] p_sum;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TS_IDLE:    if (in_valid) state_nx = TS_MUL_AC;
            TS_MUL_AC:  state_nx = TS_MUL_BD;
            TS_MUL_BD:  state_nx = TS_MUL_SUM;
            TS_MUL_SUM: state_nx = TS_COMBINE;
            TS_COMBINE: state_nx = TS_IDLE;
            default:    state_nx = TS_IDLE;
        endcase
    end

    // The one shared multiplier, operands chosen by state
    always_comb begin
        op_x = '0;
        op_y = '0;
        unique case (state)
            TS_MUL_AC:  begin op_x = ra;   op_y = rc;   end
            TS_MUL_BD:  begin op_x = rb;   op_y = rd;   end
            TS_MUL_SUM: begin op_x = rsab; op_y = rscd; end
            default:    begin op_x = '0;   op_y = '0;   end
        endcase
    end
    assign prod     = PW'(op_x) * PW'(op_y);
    assign in_ready = (state == TS_IDLE);

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ra <= '0; rb <= '0; rc <= '0; rd <= '0;
            rsab <= '0; rscd <= '0;
            p_ac <= '0; p_bd <= '0; p_sum <= '0;
            out_re <= '0; out_im <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (state)
                TS_IDLE: if (in_valid) begin
                    ra   <= SW'(a);
                    rb   <= SW'(b);
                    rc   <= SW'(c);
                    rd   <= SW'(d);
                    rsab <= SW'(a) + SW'(b);
                    rscd <= SW'(c) + SW'(d);
                end
                TS_MUL_AC:  p_ac  <= MW'(prod);
                TS_MUL_BD:  p_bd  <= MW'(prod);
                TS_MUL_SUM: p_sum <= prod;
                TS_COMBINE: begin
                    out_re    <= RW'(p_ac) - RW'(p_bd);
                    out_im    <= RW'(p_sum - PW'(p_ac) - PW'(p_bd));
                    out_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cmul3_narrow.sv
module cmul3_narrow #(
    parameter int IW = 17,
    parameter int OW = 8
) (
    input  logic signed [IW-1:0] full,
    input  logic                 rnd,
    output logic signed [OW-1:0] q
);
    localparam int SH = IW - OW;
    localparam logic signed [IW:0] HALF = (IW+1)'(1) << (SH - 1);

    logic signed [IW:0] biased;

    assign biased = {full[IW-1], full} + (rnd ? HALF : '0);
    assign q      = OW'(biased >>> SH);
endmodule

// File: rtl/cmul3.sv
module cmul3
    import cmul3_pkg::*;
#(
    parameter int W      = 8,
    parameter int NW     = 8,
    parameter bit SHARED = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [W-1:0]  a_re,
    input  logic signed [W-1:0]  a_im,
    input  logic signed [W-1:0]  b_re,
    input  logic signed [W-1:0]  b_im,
    input  logic                 rnd_sel,
    output logic                 out_valid,
    output logic signed [2*W:0]  out_re,
    output logic signed [2*W:0]  out_im,
    output logic signed [NW-1:0] out_re_n,
    output logic signed [NW-1:0] out_im_n
);
    localparam int RW = 2 * W + 1;

    generate
        if (SHARED) begin : g_shared
            cmul3_seq #(.W(W)) u_core (
                .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
                .a(a_re), .b(a_im), .c(b_re), .d(b_im),
                .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
            );
        end else begin : g_pipe
            assign in_ready = 1'b1;
            cmul3_pipe #(.W(W)) u_core (
                .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
                .a(a_re), .b(a_im), .c(b_re), .d(b_im),
                .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
            );
        end
    endgenerate

    cmul3_narrow #(.IW(RW), .OW(NW)) u_nar_re (.full(out_re), .rnd(rnd_sel), .q(out_re_n));
    cmul3_narrow #(.IW(RW), .OW(NW)) u_nar_im (.full(out_im), .rnd(rnd_sel), .q(out_im_n));
endmodule

// File: rtl/cmul3_chk.sv
module cmul3_chk #(
    parameter int W      = 8,
    parameter int NW     = 8,
    parameter bit SHARED = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic signed [W-1:0]  a_re,
    input logic signed [W-1:0]  a_im,
    input logic signed [W-1:0]  b_re,
    input logic signed [W-1:0]  b_im,
    input logic                 rnd_sel,
    input logic                 out_valid,
    input logic signed [2*W:0]  out_re,
    input logic signed [2*W:0]  out_im,
    input logic signed [NW-1:0] out_re_n,
    input logic signed [NW-1:0] out_im_n
);
    localparam int RW = 2 * W + 1;
    localparam int SH = RW - NW;

    // Edges since reset release, saturating at the fixed latency of 5
    logic [2:0] age;
    logic       warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age <= '0;
        else if (age != 3'd5) age <= age + 3'd1;
    end
    assign warm = (age == 3'd5);

    logic signed [NW-1:0] tr_re, tr_im;
    assign tr_re = NW'(out_re >>> SH);
    assign tr_im = NW'(out_im >>> SH);

    AST_VALID_COLD: assert property (@(posedge clk) disable iff (!rst_n) !warm |-> !out_valid); // R7
    AST_VALID_LAT:  assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid && in_ready, 5))); // R4
    AST_RE_EXACT:   assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid) |-> (int'(out_re) == int'($past(a_re, 5)) * int'($past(b_re, 5))
                                              - int'($past(a_im, 5)) * int'($past(b_im, 5)))); // R2
    AST_IM_EXACT:   assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid) |-> (int'(out_im) == int'($past(a_re, 5)) * int'($past(b_im, 5))
                                              + int'($past(a_im, 5)) * int'($past(b_re, 5)))); // R3
    AST_TRUNC_RE:   assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !rnd_sel) |-> (out_re_n == tr_re && out_im_n == tr_im)); // R5
    AST_RND_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rnd_sel) |-> ((out_re_n == tr_re || out_re_n == NW'(tr_re + 1'b1)) &&
                                    (out_im_n == tr_im || out_im_n == NW'(tr_im + 1'b1)))); // R6

    generate
        if (SHARED) begin : g_ts
            AST_TS_BUSY:  assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_ready) |=> !in_ready); // R8
            AST_TS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (in_ready && !$past(in_ready))); // R8
        end else begin : g_pp
            AST_PIPE_READY: assert property (@(posedge clk) disable iff (!rst_n) in_ready); // R1
        end
    endgenerate
endmodule

bind cmul3 cmul3_chk #(.W(W), .NW(NW), .SHARED(SHARED)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .rnd_sel(rnd_sel),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
    .out_re_n(out_re_n), .out_im_n(out_im_n)
);

// File: tb/tb_cmul3.sv
`timescale 1ns/1ps
module tb_cmul3;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // Pipelined instance
    logic p_valid = 1'b0, p_ready, p_rnd = 1'b0, p_ovalid;
    logic signed [7:0] p_a = '0, p_b = '0, p_c = '0, p_d = '0;
    logic signed [16:0] p_re, p_im;
    logic signed [7:0] p_ren, p_imn;

    cmul3 #(.W(8), .NW(8), .SHARED(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(p_valid), .in_ready(p_ready),
        .a_re(p_a), .a_im(p_b), .b_re(p_c), .b_im(p_d), .rnd_sel(p_rnd),
        .out_valid(p_ovalid), .out_re(p_re), .out_im(p_im),
        .out_re_n(p_ren), .out_im_n(p_imn)
    );

    // Time-shared instance
    logic t_valid = 1'b0, t_ready, t_rnd = 1'b1, t_ovalid;
    logic signed [7:0] t_a = '0, t_b = '0, t_c = '0, t_d = '0;
    logic signed [16:0] t_re, t_im;
    logic signed [7:0] t_ren, t_imn;

    cmul3 #(.W(8), .NW(8), .SHARED(1'b1)) dut_ts (
        .clk(clk), .rst_n(rst_n), .in_valid(t_valid), .in_ready(t_ready),
        .a_re(t_a), .a_im(t_b), .b_re(t_c), .b_im(t_d), .rnd_sel(t_rnd),
        .out_valid(t_ovalid), .out_re(t_re), .out_im(t_im),
        .out_re_n(t_ren), .out_im_n(t_imn)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Bench-side history of what was driven into the pipelined instance
    bit hv [0:4];
    int ha [0:4], hb [0:4], hc [0:4], hd [0:4];

    function automatic int nar(int x, bit r);
        return r ? ((x + 256) >>> 9) : (x >>> 9);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check the pipelined outputs against the sample driven five steps ago,
    // then drive the next one; one call per clock, at the falling edge.
    task automatic pipe_step(bit v, int a, int b, int c, int d, string req);
        chk({req, " R1 ready"}, int'(p_ready), 1);
        chk({req, " R4 valid"}, int'(p_ovalid), int'(hv[4]));
        if (hv[4] && p_ovalid) begin
            int er, ei;
            er = ha[4] * hc[4] - hb[4] * hd[4];
            ei = ha[4] * hd[4] + hb[4] * hc[4];
            chk({req, " R2 re"}, int'(p_re), er);
            chk({req, " R3 im"}, int'(p_im), ei);
            chk(p_rnd ? {req, " R6 re_n"} : {req, " R5 re_n"}, int'(p_ren), nar(er, p_rnd));
            chk(p_rnd ? {req, " R6 im_n"} : {req, " R5 im_n"}, int'(p_imn), nar(ei, p_rnd));
        end
        for (int k = 4; k > 0; k--) begin
            hv[k] = hv[k-1]; ha[k] = ha[k-1]; hb[k] = hb[k-1]; hc[k] = hc[k-1]; hd[k] = hd[k-1];
        end
        hv[0] = v; ha[0] = a; hb[0] = b; hc[0] = c; hd[0] = d;
        p_valid = v; p_a = 8'(a); p_b = 8'(b); p_c = 8'(c); p_d = 8'(d);
        @(negedge clk);
    endtask

    task automatic pipe_flush(string req);
        for (int i = 0; i < 6; i++) pipe_step(1'b0, 0, 0, 0, 0, req);
    endtask

    task automatic t_reset_state();
        chk("R7 valid", int'(p_ovalid), 0);
        chk("R7 re", int'(p_re), 0);
        chk("R7 im", int'(p_im), 0);
        chk("R7 ready", int'(p_ready), 1);
        chk("R7 ts ready", int'(t_ready), 1);
        chk("R7 ts valid", int'(t_ovalid), 0);
    endtask

    task automatic t_single();
        pipe_step(1'b1, 3, -5, 7, 2, "single");
        pipe_flush("single");
    endtask

    task automatic t_stream();
        for (int i = 0; i < 14; i++) begin
            bit v;
            v = (i != 9);
            pipe_step(v, ((i * 37) % 256) - 128, ((i * 91 + 13) % 256) - 128,
                      ((i * 53 + 7) % 256) - 128, ((i * 29 + 101) % 256) - 128, "stream");
        end
        pipe_flush("stream");
    endtask

    task automatic t_extremes();
        pipe_step(1'b1, -128, -128, -128, -128, "R10 ext");
        pipe_step(1'b1, -128, -128, -128, 127, "R10 ext");
        pipe_step(1'b1, 127, -128, 127, 127, "R10 ext");
        pipe_step(1'b1, -128, 127, 127, -128, "R10 ext");
        pipe_flush("R10 ext");
    endtask

    task automatic t_narrow(bit r);
        p_rnd = r;
        pipe_step(1'b1, 16, 0, 16, 0, "narrow");   // +256: tie
        pipe_step(1'b1, 16, 0, -16, 0, "narrow");  // -256: tie
        pipe_step(1'b1, 32, 0, 24, 0, "narrow");   // +768: tie
        pipe_step(1'b1, -3, 7, 11, -2, "narrow");
        pipe_step(1'b1, 100, -57, -90, 33, "narrow");
        pipe_flush("narrow");
        p_rnd = 1'b0;
    endtask

    // Time-shared: one sample; with noisy=1 in_valid stays high with junk
    // operands while the block is busy.
    task automatic ts_sample(int a, int b, int c, int d, bit noisy, string req);
        int er, ei;
        er = a * c - b * d;
        ei = a * d + b * c;
        chk({req, " R8 ready idle"}, int'(t_ready), 1);
        t_valid = 1'b1; t_a = 8'(a); t_b = 8'(b); t_c = 8'(c); t_d = 8'(d);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (i == 4) t_valid = 1'b0;
            else begin
                t_valid = noisy;
                t_a = 8'(a + 17 * i); t_b = 8'(b - 5); t_c = 8'(c ^ 8'h55); t_d = 8'(d + 3);
            end
            chk({req, " R8 ready busy"}, int'(t_ready), 0);
            chk({req, " R4 ts no early valid"}, int'(t_ovalid), 0);
        end
        @(negedge clk);
        chk({req, " R4 ts valid"}, int'(t_ovalid), 1);
        chk({req, " R8 ready back"}, int'(t_ready), 1);
        chk({req, " R2 ts re"}, int'(t_re), er);
        chk({req, " R3 ts im"}, int'(t_im), ei);
        chk({req, " R6 ts re_n"}, int'(t_ren), nar(er, 1'b1));
        chk({req, " R6 ts im_n"}, int'(t_imn), nar(ei, 1'b1));
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk({req, " R9 no extra result"}, int'(t_ovalid), 0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        for (int k = 0; k < 5; k++) begin
            hv[k] = 1'b0; ha[k] = 0; hb[k] = 0; hc[k] = 0; hd[k] = 0;
        end
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_single();
        t_stream();
        t_extremes();
        t_narrow(1'b0);
        t_narrow(1'b1);
        ts_sample(3, -5, 7, 2, 1'b0, "ts basic");
        ts_sample(-128, -128, -128, -128, 1'b0, "ts R10");
        ts_sample(16, 0, 16, 0, 1'b1, "ts noisy");
        ts_sample(-77, 45, 120, -99, 1'b1, "ts noisy");
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R4 actual=running expected=finished");
        summary();
        $finish;
    end
endmodule